// File: doc/BRIEF.md
# Variable-Page Address Translation Buffer

This block translates a 32-bit effective address into a 32-bit real address. It does so by searching a small table of translations held in registers, and every entry takes part in each lookup. Each entry describes one page, and that page can be one of four sizes. An entry also carries an address-space tag, a flag that makes it visible in every address space, a four-bit access-group index, a modified flag, no-execute and guarded flags, and an optional split of a 4 KiB page into four 1 KiB pieces that are valid independently.

A lookup presents the effective address, the access kind, the current address-space ID and a translation-enable bit. One cycle later a registered result reports one of four outcomes: a good translation, a miss, a modified-flag fault or an execution fault. On a miss, software refills the table through the write port. It can use the round-robin index that the block offers. An invalidate-by-address command and a flush-everything input remove stale translations.

Top module: `xlate_buf`

## Requirements
- R1: When `lk_xlate_en` is 0, a lookup reports `res_ok`=1 and `res_ra` equal to `lk_ea`, with `res_grp`=0, whatever the table holds.
- R2: Page size codes are 0=4 KiB, 1=16 KiB, 2=512 KiB and 3=8 MiB. An entry matches when the effective address equals its virtual page number in the bits above the page offset. The real address is the entry's real page bits above the offset, joined to the effective-address bits below it.
- R3: When a 4 KiB entry has subpaging enabled, it matches only if `wr_sub_valid[ea[11:10]]` was set when the entry was written. Otherwise the lookup misses.
- R4: An entry matches only when its address-space tag equals `lk_asid`, unless its shared flag is set.
- R5: On a good translation, `res_grp` gives the group index of the entry used. On every other outcome `res_grp` is 0.
- R6: A store (`lk_kind`=1) that hits an entry with its modified flag clear reports `res_chg_fault` with `res_ok`=0, `res_ra`=0 and `res_grp`=0. Loads (0) to the same entry translate normally.
- R7: A fetch (`lk_kind`=2) that hits an entry marked no-execute or guarded reports `res_exec_fault`, with `res_ra`=0 and `res_grp`=0.
- R8: A translated lookup that matches no valid entry reports `res_miss` for one cycle and changes no entry.
- R9: When several valid entries match, the lowest-indexed one is used.
- R10: Results appear in the cycle after `lk_valid`. In that cycle `res_valid` is 1 and exactly one of the four outcome flags is set. Otherwise all result outputs are 0, and they are 0 after reset.
- R11: Invalidate compares `inv_ea` (effective-address bits 31:10) with each entry at that entry's page granularity. It ignores the address-space tag and clears every entry that matches.
- R12: `flush_all` clears every entry in one cycle and overrides a write made in the same cycle.
- R13: `repl_idx` is 0 after reset and steps by one on every write, wrapping from 31 to 0.
- R14: A written entry is valid from the next cycle, including when an invalidate that would match it arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_xlate_en | input | 1 | Translation enable for this access |
| lk_kind | input | 2 | 0 load, 1 store, 2 fetch |
| lk_asid | input | 4 | Current address-space ID |
| lk_ea | input | 32 | Effective address |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 5 | Entry index to load |
| wr_vpn | input | 20 | Virtual page number (address bits 31:12) |
| wr_rpn | input | 20 | Real page number (address bits 31:12) |
| wr_size | input | 2 | Page size code |
| wr_asid | input | 4 | Address-space tag |
| wr_shared | input | 1 | Match in every address space |
| wr_grp | input | 4 | Access-group index |
| wr_changed | input | 1 | Modified flag |
| wr_noexec | input | 1 | No-execute flag |
| wr_guarded | input | 1 | Guarded flag |
| wr_sub_en | input | 1 | Enable 1 KiB subpages (4 KiB pages) |
| wr_sub_valid | input | 4 | Per-subpage valid bits |
| inv_en | input | 1 | Invalidate by address |
| inv_ea | input | 22 | Effective-address bits 31:10 to invalidate |
| flush_all | input | 1 | Clear all entries |
| repl_idx | output | 5 | Suggested refill index |
| res_valid | output | 1 | Result present |
| res_ok | output | 1 | Good translation |
| res_miss | output | 1 | No match |
| res_chg_fault | output | 1 | Store to unmodified page |
| res_exec_fault | output | 1 | Fetch from no-execute or guarded page |
| res_ra | output | 32 | Real address |
| res_grp | output | 4 | Access-group index |

## Verification
The bench aims at the page-offset boundary of each size. A wrong mask would leak effective-address bits into the real page or miss aliases inside a large page. It also probes an invalid 1 KiB subpage inside an otherwise valid 4 KiB page, and a shared entry seen from a foreign address space. It sets up overlapping entries that expose a wrong priority order. Invalidate runs with random low address bits, and with a write to the same entry in the same cycle. Flush and write arrive together. The replacement pointer is checked across its wrap. Random lookups over a table with random sizes and flags are compared with a model in the bench, so fault ordering errors and stale entries also show up.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int EA_W  = 32;
    localparam int PN_W  = 20;
    localparam int ASID_W = 4;
    localparam int GRP_W  = 4;
    localparam int SUB_N  = 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_16K  = 2'd1,
        PG_512K = 2'd2,
        PG_8M   = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic              valid;
        pgsz_e             size;
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   rpn;
        logic [ASID_W-1:0] asid;
        logic              shared;
        logic [GRP_W-1:0]  grp;
        logic              changed;
        logic              noexec;
        logic              guarded;
        logic              sub_en;
        logic [SUB_N-1:0]  sub_valid;
    } xl_entry_t;

    // page-number bits that take part in the compare for each size
    function automatic logic [PN_W-1:0] page_mask(pgsz_e sz);
        case (sz)
            PG_4K:   page_mask = 20'hFFFFF;
            PG_16K:  page_mask = 20'hFFFFC;
            PG_512K: page_mask = 20'hFFF80;
            default: page_mask = 20'hFF800;
        endcase
    endfunction

endpackage

// File: rtl/xlate_prio.sv
module xlate_prio #(
    parameter int N = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/xlate_rr.sv
module xlate_rr #(
    parameter int N = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
    end

    p_rr_step_r13: assert property (@(posedge clk) disable iff (rst)
        step |=> (($past(ptr) == IDX_W'(N - 1)) ? (ptr == '0) : (ptr == $past(ptr) + 1'b1)));
endmodule

// File: rtl/xlate_array.sv
module xlate_array
    import xlate_pkg::*;
#(
    parameter int N = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  xl_entry_t         wr_data,
    input  logic              inv_en,
    input  logic [PN_W-1:0]   inv_pn,
    input  logic [PN_W-1:0]   lk_pn,
    input  logic [1:0]        lk_sub,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N-1:0]      hit_vec,
    output xl_entry_t [N-1:0] tab
);
    logic [N-1:0] valid_vec;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [PN_W-1:0] msk;
        logic            pg_eq, sub_ok, as_ok, inv_hit, wr_here;

        assign msk     = page_mask(tab[g].size);
        assign pg_eq   = ((lk_pn ^ tab[g].vpn) & msk) == '0;
        assign sub_ok  = !(tab[g].size == PG_4K && tab[g].sub_en) || tab[g].sub_valid[lk_sub];
        assign as_ok   = tab[g].shared || (tab[g].asid == lk_asid);
        assign hit_vec[g] = tab[g].valid && pg_eq && sub_ok && as_ok;
        assign inv_hit = inv_en && (((inv_pn ^ tab[g].vpn) & msk) == '0);
        assign wr_here = wr_en && (wr_idx == IDX_W'(g));
        assign valid_vec[g] = tab[g].valid;

        always_ff @(posedge clk) begin
            if (rst) begin
                tab[g] <= '0;
            end else if (flush) begin
                tab[g].valid <= 1'b0;
            end else if (wr_here) begin
                tab[g]       <= wr_data;
                tab[g].valid <= 1'b1;
            end else if (inv_hit) begin
                tab[g].valid <= 1'b0;
            end
        end
    end

    p_flush_empty_r12: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    p_write_loads_r14: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
    import xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic             lk_xlate_en,
    input  logic [1:0]       lk_kind,
    input  logic [3:0]       lk_asid,
    input  logic [31:0]      lk_ea,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [19:0]      wr_vpn,
    input  logic [19:0]      wr_rpn,
    input  logic [1:0]       wr_size,
    input  logic [3:0]       wr_asid,
    input  logic             wr_shared,
    input  logic [3:0]       wr_grp,
    input  logic             wr_changed,
    input  logic             wr_noexec,
    input  logic             wr_guarded,
    input  logic             wr_sub_en,
    input  logic [3:0]       wr_sub_valid,
    input  logic             inv_en,
    input  logic [21:0]      inv_ea,
    input  logic             flush_all,
    output logic [IDX_W-1:0] repl_idx,
    output logic             res_valid,
    output logic             res_ok,
    output logic             res_miss,
    output logic             res_chg_fault,
    output logic             res_exec_fault,
    output logic [31:0]      res_ra,
    output logic [3:0]       res_grp
);
    xl_entry_t                   wr_data;
    xl_entry_t [NUM_ENTRIES-1:0] tab;
    logic [NUM_ENTRIES-1:0]      hit_vec;
    logic                        hit_any;
    logic [IDX_W-1:0]            hit_idx;
    xl_entry_t                   sel;
    logic [PN_W-1:0]             sel_msk;
    acc_e                        kind;

    logic        n_ok, n_miss, n_chg, n_exc;
    logic [31:0] n_ra;
    logic [3:0]  n_grp;

    logic unused_bits;
    assign unused_bits = ^{inv_ea[1:0], sel.valid, sel.vpn, sel.asid, sel.shared,
                           sel.sub_en, sel.sub_valid};

    always_comb begin
        wr_data           = '0;
        wr_data.valid     = 1'b1;
        wr_data.size      = pgsz_e'(wr_size);
        wr_data.vpn       = wr_vpn;
        wr_data.rpn       = wr_rpn;
        wr_data.asid      = wr_asid;
        wr_data.shared    = wr_shared;
        wr_data.grp       = wr_grp;
        wr_data.changed   = wr_changed;
        wr_data.noexec    = wr_noexec;
        wr_data.guarded   = wr_guarded;
        wr_data.sub_en    = wr_sub_en;
        wr_data.sub_valid = wr_sub_valid;
    end

    xlate_array #(.N(NUM_ENTRIES)) u_array (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_all),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .inv_en  (inv_en),
        .inv_pn  (inv_ea[21:2]),
        .lk_pn   (lk_ea[31:12]),
        .lk_sub  (lk_ea[11:10]),
        .lk_asid (lk_asid),
        .hit_vec (hit_vec),
        .tab     (tab)
    );

    xlate_prio #(.N(NUM_ENTRIES)) u_prio (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    xlate_rr #(.N(NUM_ENTRIES)) u_rr (
        .clk  (clk),
        .rst  (rst),
        .step (wr_en),
        .ptr  (repl_idx)
    );

    assign sel     = tab[hit_idx];
    assign sel_msk = page_mask(sel.size);
    assign kind    = acc_e'(lk_kind);

    always_comb begin
        n_ok  = 1'b0;
        n_miss = 1'b0;
        n_chg = 1'b0;
        n_exc = 1'b0;
        n_ra  = '0;
        n_grp = '0;
        if (!lk_xlate_en) begin
            n_ok = 1'b1;
            n_ra = lk_ea;
        end else if (!hit_any) begin
            n_miss = 1'b1;
        end else if (kind == ACC_FETCH && (sel.noexec || sel.guarded)) begin
            n_exc = 1'b1;
        end else if (kind == ACC_STORE && !sel.changed) begin
            n_chg = 1'b1;
        end else begin
            n_ok  = 1'b1;
            n_ra  = {(sel.rpn & sel_msk) | (lk_ea[31:12] & ~sel_msk), lk_ea[11:0]};
            n_grp = sel.grp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !lk_valid) begin
            res_valid      <= 1'b0;
            res_ok         <= 1'b0;
            res_miss       <= 1'b0;
            res_chg_fault  <= 1'b0;
            res_exec_fault <= 1'b0;
            res_ra         <= '0;
            res_grp        <= '0;
        end else begin
            res_valid      <= 1'b1;
            res_ok         <= n_ok;
            res_miss       <= n_miss;
            res_chg_fault  <= n_chg;
            res_exec_fault <= n_exc;
            res_ra         <= n_ra;
            res_grp        <= n_grp;
        end
    end

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones({res_ok, res_miss, res_chg_fault, res_exec_fault}) == 1));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ({res_ok, res_miss, res_chg_fault, res_exec_fault, res_ra, res_grp} == '0));

    p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_xlate_en) |=> (res_ok && res_ra == $past(lk_ea)));

    p_fault_no_ra_r6: assert property (@(posedge clk) disable iff (rst)
        (res_chg_fault || res_exec_fault || res_miss) |-> (res_ra == '0 && res_grp == '0));
endmodule

// File: tb/xlate_buf_tb.sv
module xlate_buf_tb;
    import xlate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, lk_xlate_en = 0;
    logic [1:0]  lk_kind = 0;
    logic [3:0]  lk_asid = 0;
    logic [31:0] lk_ea = 0;
    logic        wr_en = 0;
    logic [4:0]  wr_idx = 0;
    logic [19:0] wr_vpn = 0, wr_rpn = 0;
    logic [1:0]  wr_size = 0;
    logic [3:0]  wr_asid = 0, wr_grp = 0, wr_sub_valid = 0;
    logic        wr_shared = 0, wr_changed = 0, wr_noexec = 0, wr_guarded = 0, wr_sub_en = 0;
    logic        inv_en = 0;
    logic [21:0] inv_ea = 0;
    logic        flush_all = 0;
    logic [4:0]  repl_idx;
    logic        res_valid, res_ok, res_miss, res_chg_fault, res_exec_fault;
    logic [31:0] res_ra;
    logic [3:0]  res_grp;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int m_ptr = 0;
    xl_entry_t mdl [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_buf u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] b_mask(logic [1:0] sz);
        int sh;
        sh = (sz == 0) ? 0 : (sz == 1) ? 2 : (sz == 2) ? 7 : 11;
        return ~((20'd1 << sh) - 20'd1);
    endfunction

    task automatic write_ent(input int idx, input logic [1:0] sz, input logic [19:0] vpn,
                             input logic [19:0] rpn, input logic [3:0] asid, input logic sh,
                             input logic [3:0] grp, input logic chg, input logic nx,
                             input logic gd, input logic se, input logic [3:0] sv,
                             input logic also_flush);
        @(negedge clk);
        wr_en = 1; wr_idx = 5'(idx); wr_size = sz; wr_vpn = vpn; wr_rpn = rpn;
        wr_asid = asid; wr_shared = sh; wr_grp = grp; wr_changed = chg;
        wr_noexec = nx; wr_guarded = gd; wr_sub_en = se; wr_sub_valid = sv;
        flush_all = also_flush;
        if (also_flush) begin
            for (int i = 0; i < N; i++) mdl[i].valid = 0;
        end else begin
            mdl[idx].valid = 1; mdl[idx].size = pgsz_e'(sz); mdl[idx].vpn = vpn;
            mdl[idx].rpn = rpn; mdl[idx].asid = asid; mdl[idx].shared = sh;
            mdl[idx].grp = grp; mdl[idx].changed = chg; mdl[idx].noexec = nx;
            mdl[idx].guarded = gd; mdl[idx].sub_en = se; mdl[idx].sub_valid = sv;
        end
        m_ptr = (m_ptr + 1) % N;
        @(negedge clk);
        wr_en = 0; flush_all = 0;
    endtask

    task automatic invalidate(input logic [21:0] ea_hi);
        @(negedge clk);
        inv_en = 1; inv_ea = ea_hi;
        for (int i = 0; i < N; i++)
            if (((ea_hi[21:2] ^ mdl[i].vpn) & b_mask(mdl[i].size)) == 0) mdl[i].valid = 0;
        @(negedge clk);
        inv_en = 0;
    endtask

    task automatic lookup(input string req, input logic xen, input logic [1:0] kind,
                          input logic [3:0] asid, input logic [31:0] ea);
        logic [3:0]  e_flags;
        logic [31:0] e_ra;
        logic [3:0]  e_grp;
        int          hit;
        @(negedge clk);
        lk_valid = 1; lk_xlate_en = xen; lk_kind = kind; lk_asid = asid; lk_ea = ea;
        hit = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (mdl[i].valid && (((ea[31:12] ^ mdl[i].vpn) & b_mask(mdl[i].size)) == 0)
                && (mdl[i].shared || mdl[i].asid == asid)
                && (!(mdl[i].size == PG_4K && mdl[i].sub_en) || mdl[i].sub_valid[ea[11:10]]))
                hit = i;
        end
        e_ra = 0; e_grp = 0;
        if (!xen) begin
            e_flags = 4'b1000; e_ra = ea;
        end else if (hit < 0) begin
            e_flags = 4'b0100;
        end else if (kind == 2 && (mdl[hit].noexec || mdl[hit].guarded)) begin
            e_flags = 4'b0001;
        end else if (kind == 1 && !mdl[hit].changed) begin
            e_flags = 4'b0010;
        end else begin
            e_flags = 4'b1000;
            e_ra = {(mdl[hit].rpn & b_mask(mdl[hit].size)) |
                    (ea[31:12] & ~b_mask(mdl[hit].size)), ea[11:0]};
            e_grp = mdl[hit].grp;
        end
        @(negedge clk);
        lk_valid = 0;
        chk({req, " R10 valid"}, 32'(res_valid), 32'd1);
        chk({req, " flags"}, 32'({res_ok, res_miss, res_chg_fault, res_exec_fault}), 32'(e_flags));
        chk({req, " ra"}, res_ra, e_ra);
        chk({req, " R5 grp"}, 32'(res_grp), 32'(e_grp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 / R13 reset state
        chk("R10 reset outputs", 32'({res_valid, res_ok, res_miss, res_chg_fault,
                                      res_exec_fault, res_grp}) | res_ra, 32'd0);
        chk("R13 reset repl_idx", 32'(repl_idx), 32'd0);

        lookup("R1 bypass", 0, 0, 0, 32'hDEAD_BEEF);
        lookup("R8 empty miss", 1, 0, 0, 32'h1234_5678);

        // R2: one entry per size, probing both ends of each page
        write_ent(0, 0, 20'h10001, 20'hA0001, 1, 0, 4'h1, 1, 0, 0, 0, 0, 0);
        write_ent(1, 1, 20'h20004, 20'hB0008, 1, 0, 4'h2, 1, 0, 0, 0, 0, 0);
        write_ent(2, 2, 20'h30080, 20'hC0100, 1, 0, 4'h3, 1, 0, 0, 0, 0, 0);
        write_ent(3, 3, 20'h40800, 20'hD1000, 1, 0, 4'h4, 1, 0, 0, 0, 0, 0);
        lookup("R2 4K", 1, 0, 1, 32'h1000_1FFF);
        lookup("R2 4K next page", 1, 0, 1, 32'h1000_2000);
        lookup("R2 16K top", 1, 0, 1, 32'h2000_7FFF);
        lookup("R2 16K past", 1, 0, 1, 32'h2000_8000);
        lookup("R2 512K", 1, 0, 1, 32'h300F_ABCD);
        lookup("R2 8M", 1, 0, 1, 32'h40FF_FFFF);
        lookup("R2 8M past", 1, 0, 1, 32'h4100_0000);
        chk("R2 8M ra", res_ra, 32'h0);
        lookup("R4 asid mismatch", 1, 0, 2, 32'h1000_1000);
        write_ent(4, 0, 20'h50005, 20'hE0005, 9, 1, 4'h7, 1, 0, 0, 0, 0, 0);
        lookup("R4 shared", 1, 0, 3, 32'h5000_5123);
        // R3 subpages 0 and 2 valid
        write_ent(5, 0, 20'h60006, 20'hF0006, 1, 0, 4'h5, 1, 0, 0, 1, 4'b0101, 0);
        lookup("R3 sub0", 1, 0, 1, 32'h6000_6000);
        lookup("R3 sub1 invalid", 1, 0, 1, 32'h6000_6400);
        lookup("R3 sub2", 1, 0, 1, 32'h6000_6BFF);
        // R6 and R7
        write_ent(6, 0, 20'h70007, 20'h17007, 1, 0, 4'h6, 0, 0, 0, 0, 0, 0);
        lookup("R6 store unmodified", 1, 1, 1, 32'h7000_7010);
        lookup("R6 load unmodified", 1, 0, 1, 32'h7000_7010);
        write_ent(7, 0, 20'h80008, 20'h18008, 1, 0, 4'h8, 1, 0, 1, 0, 0, 0);
        write_ent(8, 0, 20'h90009, 20'h19009, 1, 0, 4'h9, 1, 1, 0, 0, 0, 0);
        lookup("R7 fetch guarded", 1, 2, 1, 32'h8000_8000);
        lookup("R7 fetch noexec", 1, 2, 1, 32'h9000_9000);
        lookup("R7 load guarded", 1, 0, 1, 32'h8000_8000);
        // R9 overlap: index 10 and 11 cover same page
        write_ent(11, 0, 20'hA000A, 20'h2B00B, 1, 0, 4'hB, 1, 0, 0, 0, 0, 0);
        write_ent(10, 1, 20'hA0008, 20'h2A008, 1, 0, 4'hA, 1, 0, 0, 0, 0, 0);
        lookup("R9 lowest index", 1, 0, 1, 32'hA000_A444);
        // R11 invalidate at 16K granularity with arbitrary low bits
        invalidate({20'hA0009, 2'b11});
        lookup("R11 inv large", 1, 0, 1, 32'hA000_A444);
        invalidate({20'hA000A, 2'b01});
        lookup("R11 inv 4K", 1, 0, 1, 32'hA000_A444);
        lookup("R11 others kept", 1, 0, 1, 32'h1000_1234);
        // R14 write wins over same-cycle invalidate
        @(negedge clk);
        wr_en = 1; wr_idx = 12; wr_size = 0; wr_vpn = 20'hC000C; wr_rpn = 20'h3C00C;
        wr_asid = 1; wr_shared = 0; wr_grp = 4'hC; wr_changed = 1; wr_noexec = 0;
        wr_guarded = 0; wr_sub_en = 0; inv_en = 1; inv_ea = {20'hC000C, 2'b00};
        mdl[12] = '0; mdl[12].valid = 1; mdl[12].vpn = 20'hC000C; mdl[12].rpn = 20'h3C00C;
        mdl[12].asid = 1; mdl[12].grp = 4'hC; mdl[12].changed = 1;
        m_ptr = (m_ptr + 1) % N;
        @(negedge clk);
        wr_en = 0; inv_en = 0;
        lookup("R14 write beats inv", 1, 0, 1, 32'hC000_C004);
        chk("R13 repl_idx", 32'(repl_idx), 32'(m_ptr));

        // random traffic
        for (int i = 0; i < N; i++)
            write_ent(i, 2'($urandom_range(0, 3)), {2'($urandom_range(0, 1)), 18'($urandom)},
                      20'($urandom), 4'($urandom_range(0, 3)), 1'($urandom_range(0, 5) == 0),
                      4'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) == 0),
                      1'($urandom_range(0, 4) == 0), 1'($urandom), 4'($urandom), 0);
        chk("R13 wrap", 32'(repl_idx), 32'(m_ptr));
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ea;
            int e;
            e = $urandom_range(0, N - 1);
            ea = $urandom;
            if ($urandom_range(0, 3) != 0)
                ea[31:12] = (mdl[e].vpn & b_mask(mdl[e].size)) | (ea[31:12] & ~b_mask(mdl[e].size));
            lookup("R2 R4 R6 R7 R9 random", 1'($urandom_range(0, 9) != 0),
                   2'($urandom_range(0, 2)), 4'($urandom_range(0, 3)), ea);
            if (k % 50 == 49) invalidate(22'($urandom));
        end
        // R12 flush together with a write
        write_ent(3, 0, 20'h10001, 20'h11111, 1, 0, 4'h1, 1, 0, 0, 0, 0, 1);
        lookup("R12 flush", 1, 0, 1, 32'h1000_1000);
        lookup("R12 flush dropped write", 1, 0, mdl[0].asid, {mdl[0].vpn, 12'h0});
        @(negedge clk);
        chk("R10 idle", 32'({res_valid, res_ok, res_miss}), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule